// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block holds the operating mode of a CAN controller and turns host mode writes into the control strobes the rest of the controller needs. It has five modes: initialization, normal, loopback, monitor and sleep. On each mode change it resets the transmitter and receiver, holds the error counters, selects the internal loopback path, forces listen-only operation or enables low power. It also keeps two interrupt flags, one for wake-up and one for mode change. Each flag has its own enable.

A request for sleep does not act at once. It stays pending until the bus is idle and the transmit FIFO is empty. While the controller sleeps, any bus activity wakes it into normal mode. The block also issues bus-off recovery requests to the error logic, either automatically or when the host asks. The protocol engine, the FIFOs and the transceiver are outside the block. They appear here only as handshake inputs.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst_n` is low, `mode` reads 100 (initialization), `txrx_rst` and `errcnt_hold` are 1, and `wake_flag`, `mchg_flag`, `irq` and `recov_go` are 0.
- R2: A write (`mode_wr`=1) changes `mode` at the next clock edge. A request of 000 selects normal (reads 000), 001 selects loopback (001) and 010 selects monitor (010). Any request with bit 2 set selects initialization (reads 100). A request of 011 selects sleep (reads 011), subject to R5.
- R3: `txrx_rst` is high for exactly the one cycle that follows each transition into initialization. `errcnt_hold` is high for as long as `mode` is 100.
- R4: `loop_sel` is high only in loopback, `listen_only` only in monitor and `low_power` only in sleep. At most one of these three outputs and `errcnt_hold` is high at a time.
- R5: Sleep is entered only at an edge where `bus_idle` and `txfifo_empty` are both 1. Until then the request stays pending and the current mode does not change.
- R6: A mode write made while a sleep request is pending replaces that request. The pending sleep is then dropped.
- R7: When `bus_active` is 1 in sleep and no write is made, the block returns to normal (000) at the next edge and sets `wake_flag`.
- R8: Each edge at which `mode` changes value sets `mchg_flag`. A write that leaves the mode unchanged does not set it.
- R9: `irq` = (`wake_flag` and `wake_ie`) or (`mchg_flag` and `mchg_ie`). `wake_clr` and `mchg_clr` clear their flags at the next edge unless a new event sets the flag at that same edge, in which case the set wins.
- R10: `recov_go` is 1 in the cycle after an edge at which `bus_off` was 1 and either `auto_recover` or `host_recover` was 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strobe that writes the mode request |
| mode_req | input | 3 | Requested mode field |
| bus_idle | input | 1 | Bus has no traffic |
| txfifo_empty | input | 1 | Transmit FIFO holds no frame |
| bus_active | input | 1 | Bus activity seen (wake source) |
| bus_off | input | 1 | Error logic reports bus-off |
| auto_recover | input | 1 | Enables automatic bus-off recovery |
| host_recover | input | 1 | Host strobe that requests bus-off recovery |
| wake_ie | input | 1 | Wake-up interrupt enable |
| mchg_ie | input | 1 | Mode-change interrupt enable |
| wake_clr | input | 1 | Clears the wake-up flag |
| mchg_clr | input | 1 | Clears the mode-change flag |
| mode | output | 3 | Current mode |
| txrx_rst | output | 1 | Reset pulse to the transmitter and receiver |
| errcnt_hold | output | 1 | Holds the error counters at zero |
| loop_sel | output | 1 | Routes transmit data internally to the receiver |
| listen_only | output | 1 | Stops the transmit path from driving dominant bits |
| low_power | output | 1 | Low-power enable |
| wake_flag | output | 1 | Wake-up flag |
| mchg_flag | output | 1 | Mode-change flag |
| irq | output | 1 | Interrupt request |
| recov_go | output | 1 | Bus-off recovery request |

## Verification
All registered results — `mode`, the flags, `txrx_rst` and `recov_go` — appear one edge after the inputs that cause them. The decoded strobes and `irq` follow combinationally from those registers within the same cycle. The bench drives inputs on the falling edge. It updates a reference model on the rising edge from the same inputs, then compares every output on the next falling edge. This keeps each expected value aligned with the single register stage. The directed cases hold a sleep request pending over several busy cycles, replace it, wake from sleep, and exercise both recovery sources.

// File: rtl/can_mode_seq.sv
module can_mode_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_req,
  input  logic       bus_idle,
  input  logic       txfifo_empty,
  input  logic       bus_active,
  input  logic       bus_off,
  input  logic       auto_recover,
  input  logic       host_recover,
  input  logic       wake_ie,
  input  logic       mchg_ie,
  input  logic       wake_clr,
  input  logic       mchg_clr,
  output logic [2:0] mode,
  output logic       txrx_rst,
  output logic       errcnt_hold,
  output logic       loop_sel,
  output logic       listen_only,
  output logic       low_power,
  output logic       wake_flag,
  output logic       mchg_flag,
  output logic       irq,
  output logic       recov_go
);
  localparam logic [2:0] M_NORM  = 3'b000;
  localparam logic [2:0] M_LOOP  = 3'b001;
  localparam logic [2:0] M_MON   = 3'b010;
  localparam logic [2:0] M_SLEEP = 3'b011;
  localparam logic [2:0] M_INIT  = 3'b100;

  logic       pend, pend_nxt, wake_evt;
  logic [2:0] mode_nxt, req_mode;
  logic       sleep_ok;

  assign sleep_ok = bus_idle & txfifo_empty;
  assign req_mode = mode_req[2] ? M_INIT : mode_req;

  always_comb begin
    mode_nxt = mode;
    pend_nxt = pend;
    wake_evt = 1'b0;
    if (mode_wr) begin
      if (req_mode == M_SLEEP && mode != M_SLEEP) begin
        if (sleep_ok) begin
          mode_nxt = M_SLEEP;
          pend_nxt = 1'b0;
        end else begin
          pend_nxt = 1'b1;
        end
      end else begin
        mode_nxt = req_mode;
        pend_nxt = 1'b0;
      end
    end else if (pend && sleep_ok) begin
      mode_nxt = M_SLEEP;
      pend_nxt = 1'b0;
    end else if (mode == M_SLEEP && bus_active) begin
      mode_nxt = M_NORM;
      wake_evt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_INIT;
      pend      <= 1'b0;
      txrx_rst  <= 1'b1;
      wake_flag <= 1'b0;
      mchg_flag <= 1'b0;
      recov_go  <= 1'b0;
    end else begin
      mode      <= mode_nxt;
      pend      <= pend_nxt;
      txrx_rst  <= (mode_nxt == M_INIT) && (mode != M_INIT);
      wake_flag <= wake_evt | (wake_flag & ~wake_clr);
      mchg_flag <= (mode_nxt != mode) | (mchg_flag & ~mchg_clr);
      recov_go  <= bus_off & (auto_recover | host_recover);
    end
  end

  assign errcnt_hold = (mode == M_INIT);
  assign loop_sel    = (mode == M_LOOP);
  assign listen_only = (mode == M_MON);
  assign low_power   = (mode == M_SLEEP);
  assign irq         = (wake_flag & wake_ie) | (mchg_flag & mchg_ie);

  // R3: entry into initialization always produces the reset pulse
  a_r3_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_INIT && $past(mode) != M_INIT) |-> txrx_rst);

  // R4: mode-decoded strobes are mutually exclusive
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loop_sel, listen_only, low_power, errcnt_hold}));

  // R5: sleep entered only with idle bus and empty FIFO
  a_r5_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && $past(mode) != M_SLEEP) |-> $past(bus_idle && txfifo_empty));

  // R7: bus activity in sleep wakes into normal mode with the flag
  a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && bus_active && !mode_wr) |=> (wake_flag && mode == M_NORM));

  // R8: any mode change leaves the change flag set
  a_r8_mchg: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> mchg_flag);

  // R10: recovery request only follows bus-off
  a_r10_recov: assert property (@(posedge clk) disable iff (!rst_n)
    recov_go |-> $past(bus_off));
endmodule

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  logic       clk = 0, rst_n = 0;
  logic       mode_wr = 0, bus_idle = 1, txfifo_empty = 1, bus_active = 0;
  logic       bus_off = 0, auto_recover = 0, host_recover = 0;
  logic       wake_ie = 0, mchg_ie = 0, wake_clr = 0, mchg_clr = 0;
  logic [2:0] mode_req = 3'b000;
  logic [2:0] mode;
  logic       txrx_rst, errcnt_hold, loop_sel, listen_only, low_power;
  logic       wake_flag, mchg_flag, irq, recov_go;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  can_mode_seq dut (.*);

  always #10 clk = ~clk;

  // reference state, built from the requirements
  logic [2:0] e_mode;
  logic       e_pend, e_rst, e_wake, e_mchg, e_recov;

  function automatic logic [2:0] decode(input logic [2:0] r);
    return r[2] ? 3'b100 : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_mode <= 3'b100; e_pend <= 0; e_rst <= 1; e_wake <= 0; e_mchg <= 0; e_recov <= 0;
    end else begin
      logic [2:0] nm; logic np, wk;
      nm = e_mode; np = e_pend; wk = 0;
      if (mode_wr) begin
        if (decode(mode_req) == 3'b011 && e_mode != 3'b011) begin
          if (bus_idle && txfifo_empty) begin nm = 3'b011; np = 0; end
          else np = 1;
        end else begin nm = decode(mode_req); np = 0; end
      end else if (e_pend && bus_idle && txfifo_empty) begin
        nm = 3'b011; np = 0;
      end else if (e_mode == 3'b011 && bus_active) begin
        nm = 3'b000; wk = 1;
      end
      e_rst   <= (nm == 3'b100) && (e_mode != 3'b100);
      e_wake  <= wk | (e_wake & ~wake_clr);
      e_mchg  <= (nm != e_mode) | (e_mchg & ~mchg_clr);
      e_recov <= bus_off & (auto_recover | host_recover);
      e_mode  <= nm;
      e_pend  <= np;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    chk("R2 mode", mode, e_mode);
    chk("R3 txrx_rst", txrx_rst, e_rst);
    chk("R3 errcnt_hold", errcnt_hold, e_mode == 3'b100);
    chk("R4 loop_sel", loop_sel, e_mode == 3'b001);
    chk("R4 listen_only", listen_only, e_mode == 3'b010);
    chk("R4 low_power", low_power, e_mode == 3'b011);
    chk("R7 wake_flag", wake_flag, e_wake);
    chk("R8 mchg_flag", mchg_flag, e_mchg);
    chk("R9 irq", irq, (e_wake & wake_ie) | (e_mchg & mchg_ie));
    chk("R10 recov_go", recov_go, e_recov);
  endtask

  task automatic step();
    @(posedge clk); cyc++;
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    mode_wr = 0; bus_active = 0; host_recover = 0; wake_clr = 0; mchg_clr = 0;
  endtask

  task automatic wr(input logic [2:0] m);
    mode_req = m; mode_wr = 1; step(); mode_wr = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R1 mode", mode, 3'b100);
    chk("R1 txrx_rst", txrx_rst, 1);
    chk("R1 errcnt_hold", errcnt_hold, 1);
    chk("R1 flags", {wake_flag, mchg_flag, irq, recov_go}, 0);
    rst_n = 1;
    step();

    // R2 decode of every field value
    wr(3'b000); chk("R2 normal", mode, 3'b000);
    wr(3'b001); chk("R2 loopback", mode, 3'b001);
    wr(3'b010); chk("R2 monitor", mode, 3'b010);
    wr(3'b110); chk("R2 init 1xx", mode, 3'b100);
    chk("R3 pulse", txrx_rst, 1);
    step(); chk("R3 pulse ends", txrx_rst, 0);
    wr(3'b000);
    // R8 same-mode write leaves flag clear
    mchg_clr = 1; step(); mchg_clr = 0;
    wr(3'b000); chk("R8 same mode no flag", mchg_flag, 0);

    // R5 sleep pending while bus busy
    bus_idle = 0; wr(3'b011);
    repeat (4) step();
    chk("R5 held pending", mode, 3'b000);
    bus_idle = 1; txfifo_empty = 0; step();
    chk("R5 fifo not empty", mode, 3'b000);
    txfifo_empty = 1; step();
    chk("R5 sleep entered", mode, 3'b011);

    // R7 wake
    wake_ie = 1; wake_clr = 0; bus_active = 1; step(); bus_active = 0;
    chk("R7 woke to normal", mode, 3'b000);
    chk("R7 wake flag", wake_flag, 1);
    chk("R9 irq", irq, 1);
    wake_clr = 1; step(); wake_clr = 0;
    chk("R9 cleared", wake_flag, 0);

    // R6 replace pending sleep
    bus_idle = 0; wr(3'b011); wr(3'b001);
    bus_idle = 1; repeat (3) step();
    chk("R6 replaced", mode, 3'b001);

    // R10 host and automatic recovery
    bus_off = 1; auto_recover = 0; step();
    chk("R10 no recovery", recov_go, 0);
    host_recover = 1; step(); host_recover = 0;
    chk("R10 host", recov_go, 1);
    auto_recover = 1; step(); chk("R10 auto", recov_go, 1);
    bus_off = 0; step(); chk("R10 off", recov_go, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      mode_req     = 3'($urandom);
      mode_wr      = ($urandom % 5) == 0;
      bus_idle     = ($urandom % 2) == 0;
      txfifo_empty = ($urandom % 4) != 0;
      bus_active   = ($urandom % 8) == 0;
      bus_off      = ($urandom % 6) == 0;
      auto_recover = 1'($urandom);
      host_recover = ($urandom % 8) == 0;
      wake_ie      = 1'($urandom);
      mchg_ie      = 1'($urandom);
      wake_clr     = ($urandom % 10) == 0;
      mchg_clr     = ($urandom % 10) == 0;
      step();
    end
    quiet();
    step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule